// File: doc/BRIEF.md
# Voltage-to-Current Phase Alignment Delay

This block lines up a voltage sample stream with a current sample stream so that a small, fixed phase error from external transducers can be cancelled before any power arithmetic. An internal divider produces a step tick once every five clock cycles. Each sample path is a circular delay line that advances on that tick. The current path always lags by a fixed nominal number of steps. The voltage path lag is set by a signed 8-bit calibration code, so the voltage samples can be moved earlier or later than the current samples.

The calibration code is offset-centred. Code 0x40 gives equal lag on both paths, so there is no relative shift. Smaller codes move the voltage samples earlier and larger codes move them later, one step per code unit. Codes outside the legal window are clamped when they are written. New samples enter through a load strobe. Aligned outputs change only on a step, and a one-cycle strobe marks each step.

Top module: `phcal_align`

## Requirements
- R1: While reset is asserted and right after it, `v_out`, `i_out` and `step_o` are zero, and the calibration code is 0x40.
- R2: `step_o` is high for exactly one cycle in every five. `v_out` and `i_out` change only at the clock edge that raises `step_o`.
- R3: `v_in` and `i_in` are captured only in cycles where `smp_tick` is high. A step stores the most recently captured pair. Input values presented without `smp_tick` have no effect on any later output.
- R4: `i_out` at step k equals the current sample stored at step k-190.
- R5: `v_out` at step k equals the voltage sample stored at step k-d, where d = signed(code) + 126. Code 0x40 gives d = 190, the same lag as the current path.
- R6: Code 0x3C moves the voltage path four steps earlier than the current path (d = 186).
- R7: Code 0x82 (-126) gives d = 0, where `v_out` is the pair stored at the same step. Code 0x68 (+104) gives d = 230.
- R8: A written code read as two's complement is clamped into -126..+104. Codes below -126 act as 0x82, and codes above +104 act as 0x68.
- R9: A code written in the cycle after a step takes effect at the next step, and at every step after that.
- R10: After reset, each output is zero at step k while k is d or less (d = 190 for the current path). Zero is output until a sample has been stored d steps earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_tick | input | 1 | Load strobe for `v_in` / `i_in` |
| v_in | input | 16 | Voltage sample |
| i_in | input | 16 | Current sample |
| cal_wr | input | 1 | Calibration code write enable |
| cal_data | input | 8 | Calibration code, two's complement, zero shift at 0x40 |
| v_out | output | 16 | Shifted voltage sample |
| i_out | output | 16 | Nominally delayed current sample |
| step_o | output | 1 | High in the cycle after outputs update |

## Verification
The assertions assume that calibration writes come only after the internal reset synchronizer has released. A write is assumed to be checked in the cycle after it, with no second write in that cycle. The bench drives `smp_tick` and `cal_wr` as single-cycle pulses, and only in the cycle just after `step_o` is seen. Because of this, every load and every new code settles well before the next step. The stimulus walks through all 256 codes, including the clamped ones. It holds back one sample load to show that unlatched inputs are ignored. It resets partway through to check the fill period at the longest voltage lag.

// File: rtl/phcal_pkg.sv
package phcal_pkg;

  localparam int CODE_W = 8;

  typedef logic signed [CODE_W-1:0] code_t;

  // saturate a signed code into [lo, hi]
  function automatic code_t clamp_code(input code_t c, input int lo, input int hi);
    int v;
    v = int'(c);
    if (v < lo) v = lo;
    else if (v > hi) v = hi;
    return code_t'(v);
  endfunction

endpackage

// File: rtl/phcal_stepgen.sv
module phcal_stepgen #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic step
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q, div_d;

  always_comb begin
    step  = (div_q == LAST);
    div_d = step ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/phcal_cal_reg.sv
module phcal_cal_reg
  import phcal_pkg::*;
#(
  parameter int LO   = -126,
  parameter int HI   = 104,
  parameter int ZERO = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  output code_t             cal_o
);

  code_t cal_q, cal_d;

  always_comb begin
    cal_d = cal_q;
    if (wr_en) cal_d = clamp_code(code_t'(wr_data), LO, HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= code_t'(ZERO);
    else        cal_q <= cal_d;
  end

  assign cal_o = cal_q;

endmodule

// File: rtl/phcal_delay_line.sv
module phcal_delay_line #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [DW-1:0] din_i,
  input  logic [AW-1:0] tap_i,
  output logic [DW-1:0] dout_o
);

  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] FULL = '1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] fill_q, fill_d;
  logic [AW-1:0] raddr;
  logic [DW-1:0] dout_q, dout_d;

  always_comb begin
    raddr  = wptr_q - tap_i;
    wptr_d = wptr_q + 1'b1;
    fill_d = (fill_q == FULL) ? fill_q : fill_q + 1'b1;
    if (tap_i == '0)          dout_d = din_i;        // same-step bypass
    else if (fill_q >= tap_i) dout_d = mem[raddr];
    else                      dout_d = '0;           // not yet filled
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      fill_q <= '0;
      dout_q <= '0;
    end else if (step_i) begin
      wptr_q <= wptr_d;
      fill_q <= fill_d;
      dout_q <= dout_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (step_i) mem[wptr_q] <= din_i;
  end

  assign dout_o = dout_q;

endmodule

// File: rtl/phcal_align.sv
module phcal_align
  import phcal_pkg::*;
#(
  parameter int DW      = 16,
  parameter int DIV     = 5,
  parameter int MAX_ADV = 190,
  parameter int MAX_DLY = 40,
  parameter int ZERO    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_tick,
  input  logic [DW-1:0]     v_in,
  input  logic [DW-1:0]     i_in,
  input  logic              cal_wr,
  input  logic [CODE_W-1:0] cal_data,
  output logic [DW-1:0]     v_out,
  output logic [DW-1:0]     i_out,
  output logic              step_o
);

  localparam int LO = ZERO - MAX_ADV;
  localparam int HI = ZERO + MAX_DLY;
  localparam int AW = $clog2(MAX_ADV + MAX_DLY + 1);
  localparam logic [AW-1:0] TAP_I = AW'(MAX_ADV);

  logic          rs0_q, rs1_q, rst_s_n;
  logic          step;
  logic          step_q;
  code_t         cal_q;
  logic [AW-1:0] tap_v;
  logic [DW-1:0] hold_v_q, hold_v_d, hold_i_q, hold_i_d;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_s_n = rs1_q;

  phcal_stepgen #(.DIV(DIV)) u_step (
    .clk   (clk),
    .rst_n (rst_s_n),
    .step  (step)
  );

  phcal_cal_reg #(.LO(LO), .HI(HI), .ZERO(ZERO)) u_cal (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (cal_wr),
    .wr_data (cal_data),
    .cal_o   (cal_q)
  );

  // voltage tap: nominal lag plus signed offset from centre
  assign tap_v = AW'(int'(cal_q) - ZERO + MAX_ADV);

  always_comb begin
    hold_v_d = hold_v_q;
    hold_i_d = hold_i_q;
    if (smp_tick) begin
      hold_v_d = v_in;
      hold_i_d = i_in;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      hold_v_q <= '0;
      hold_i_q <= '0;
      step_q   <= 1'b0;
    end else begin
      hold_v_q <= hold_v_d;
      hold_i_q <= hold_i_d;
      step_q   <= step;
    end
  end

  phcal_delay_line #(.DW(DW), .AW(AW)) u_vline (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .step_i (step),
    .din_i  (hold_v_q),
    .tap_i  (tap_v),
    .dout_o (v_out)
  );

  phcal_delay_line #(.DW(DW), .AW(AW)) u_iline (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .step_i (step),
    .din_i  (hold_i_q),
    .tap_i  (TAP_I),
    .dout_o (i_out)
  );

  assign step_o = step_q;

endmodule

// File: rtl/phcal_align_chk.sv
module phcal_align_chk #(
  parameter int DW = 16,
  parameter int LO = -126,
  parameter int HI = 104,
  parameter int AW = 8
) (
  input logic                clk,
  input logic                rst_s_n,
  input logic                step_o,
  input logic [DW-1:0]       v_out,
  input logic [DW-1:0]       i_out,
  input logic                cal_wr,
  input logic [7:0]          cal_data,
  input logic signed [7:0]   cal_q,
  input logic [AW-1:0]       tap_v
);

  // R2
  step_gap_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    step_o |=> !step_o);

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !step_o |-> ($stable(v_out) && $stable(i_out)));

  // R8
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (int'(cal_q) >= LO) && (int'(cal_q) <= HI));

  // R8
  clamp_hi_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cal_wr && (int'($signed(cal_data)) > HI)) |=> (int'(cal_q) == HI));

  // R8
  clamp_lo_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cal_wr && (int'($signed(cal_data)) < LO)) |=> (int'(cal_q) == LO));

  // R9
  code_take_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cal_wr && (int'($signed(cal_data)) >= LO) && (int'($signed(cal_data)) <= HI))
      |=> (cal_q == $signed($past(cal_data))));

  // R9
  code_keep_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cal_wr |=> $stable(cal_q));

  // R5
  tap_span_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    int'(tap_v) <= (HI - LO));

endmodule

bind phcal_align phcal_align_chk #(.DW(DW), .LO(LO), .HI(HI), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .step_o   (step_o),
  .v_out    (v_out),
  .i_out    (i_out),
  .cal_wr   (cal_wr),
  .cal_data (cal_data),
  .cal_q    (cal_q),
  .tap_v    (tap_v)
);

// File: tb/phcal_align_tb.sv
`timescale 1ns/1ps
module phcal_align_tb;

  localparam int NOM  = 190;
  localparam int HMAX = 4096;

  logic        clk = 1'b0;
  logic        rst_n, smp_tick, cal_wr;
  logic [15:0] v_in, i_in;
  logic [7:0]  cal_data;
  logic [15:0] v_out, i_out;
  logic        step_o;

  int checks, fails;
  int k, dv;
  bit first_step;
  logic [15:0] hold_v, hold_i;
  logic [15:0] hist_v [HMAX];
  logic [15:0] hist_i [HMAX];

  always #2 clk = ~clk;

  phcal_align u_dut (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick),
    .v_in(v_in), .i_in(i_in), .cal_wr(cal_wr), .cal_data(cal_data),
    .v_out(v_out), .i_out(i_out), .step_o(step_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (step %0d)", req, act, exp, k);
    end
  endtask

  function automatic int model_delay(input logic [7:0] c);
    int s;
    s = int'($signed(c));
    if (s < -126) s = -126;
    if (s > 104)  s = 104;
    return s + 126;
  endfunction

  // wait for the next step, check both outputs, then optionally load a sample
  task automatic step_once(input string vtag, input bit load);
    int gap;
    string vt, it;
    gap = 0;
    do begin
      @(negedge clk);
      smp_tick = 1'b0;
      cal_wr   = 1'b0;
      gap++;
    end while (!step_o);
    if (!first_step) chk("R2", gap, 5);
    first_step = 1'b0;
    k++;
    hist_v[k] = hold_v;
    hist_i[k] = hold_i;
    vt = (k - dv < 1)  ? "R10" : vtag;
    it = (k - NOM < 1) ? "R10" : "R4";
    chk(vt, int'(v_out), (k - dv  >= 1) ? int'(hist_v[k - dv])  : 0);
    chk(it, int'(i_out), (k - NOM >= 1) ? int'(hist_i[k - NOM]) : 0);
    v_in = 16'(k * 7 + 3) | 16'h8000;
    i_in = 16'(k * 5 + 1) | 16'h4000;
    if (load) begin
      smp_tick = 1'b1;
      hold_v   = v_in;
      hold_i   = i_in;
    end else begin
      v_in = 16'hDEAD;   // R3: presented without the load strobe
      i_in = 16'hBEEF;
    end
  endtask

  task automatic write_code(input logic [7:0] c);
    cal_wr   = 1'b1;
    cal_data = c;
    dv       = model_delay(c);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    smp_tick = 1'b0;
    cal_wr = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R1", int'(v_out), 0);
      chk("R1", int'(i_out), 0);
      chk("R1", int'(step_o), 0);
    end
    rst_n = 1'b1;
    k = 0;
    dv = NOM;          // R1: code 0x40 after reset
    hold_v = '0;
    hold_i = '0;
    first_step = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    v_in = '0; i_in = '0; cal_data = '0;
    do_reset();

    // R5 / R10: default centre code, both paths fill together
    repeat (200) step_once("R5", 1'b1);

    // R6: four steps of advance
    write_code(8'h3C);
    repeat (4) step_once("R6", 1'b1);

    // R7: full advance, then a skipped load for R3
    write_code(8'h82);
    repeat (3) step_once("R7", 1'b1);
    step_once("R3", 1'b0);
    step_once("R3", 1'b1);
    step_once("R3", 1'b1);

    // R7: full delay
    write_code(8'h68);
    repeat (3) step_once("R7", 1'b1);

    // R8 / R9: every code, applied at the next step
    for (int c = 0; c < 256; c++) begin
      int s;
      s = int'($signed(8'(c)));
      write_code(8'(c));
      if (s < -126 || s > 104) repeat (2) step_once("R8", 1'b1);
      else                     repeat (2) step_once("R9", 1'b1);
    end

    // R10: refill with the longest voltage lag
    do_reset();
    step_once("R10", 1'b1);
    write_code(8'h68);
    repeat (240) step_once("R7", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule